// File: doc/BRIEF.md
# ARINC 429 Word Receiver

This block turns the two logic-level outputs of a bipolar return-to-zero line receiver into 32-bit words. One input is high while the line sits at its positive level, the other while it sits at its negative level. Neither is high while the line is at NULL. There is no clock line. The block oversamples both inputs at sixteen times the selected bit rate and accepts a bit each time a non-NULL level has held for long enough. It counts NULL samples so that it can judge the gap before a word and detect a word that stalls part-way through.

Once 32 bits have been collected, the block puts the bits back in their natural order. The label is sent most-significant bit first while the rest of the word is sent LSB first, so the label has to be reversed. The block then checks odd parity and the leading gap. Words that pass are offered on a valid/ready output. The offer stays valid with stable data until ready is seen high at a clock edge. The receiver cannot stall the line, so a word that completes while the previous one is still waiting is dropped and counted as an overrun. An 8-bit control register selects the rate and parity checking, and an 8-bit status register reports word-ready and sticky error flags.

Top module: `a429_word_rx`

## Requirements
- R1: A sample with `line_a`=1 and `line_b`=0 is a one, and `line_a`=0 with `line_b`=1 is a zero; any other combination is NULL. A bit is taken once per pulse, after its level has been seen on 3 consecutive sample ticks. A pulse shorter than that produces no bit.
- R2: The first 8 bits received form word bits 7..0 in reverse order (the first bit lands in bit 7). The following 24 bits fill bits 8..31 in arrival order. Each accepted word appears unchanged on `word_data`.
- R3: With parity checking on (`ctrl_q[1]`=1), a word whose 32 bits hold an even number of ones is not delivered and sets `status[2]`.
- R4: With parity checking off (`ctrl_q[1]`=0), a word with even parity is delivered and `status[2]` stays clear.
- R5: A word whose first pulse follows fewer than 64 NULL samples (4 bit times) is not delivered and sets `status[1]`. The next word with a proper gap is received normally.
- R6: If the line stays NULL for more than 32 samples (2 bit times) while a word is partly received, the partial bits are dropped and `status[4]` is set. A following word is received from its first bit.
- R7: `ctrl_q[0]`=1 selects high speed, with one sample tick every `DIV_HI` clocks. `ctrl_q[0]`=0 selects low speed, with one tick every `DIV_LO` clocks. Pulses sent at the high-speed timing while low speed is selected produce no word.
- R8: `word_valid` stays high and `word_data` stays stable until a clock edge with `word_ready` high. A word that completes while one is still waiting is dropped and sets `status[3]`.
- R9: Reset clears `status` and sets the control register to 8'h03. Control bits 7..2 read as zero whatever is written. `status[0]` equals `word_valid`. A `stat_clr` pulse clears `status[4:1]`. `status[7:5]` read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| line_a | input | 1 | High while the line is at its positive level |
| line_b | input | 1 | High while the line is at its negative level |
| ctrl_we | input | 1 | Writes `ctrl_wdata` into the control register |
| ctrl_wdata | input | 8 | Control write data: bit 0 high speed, bit 1 parity check |
| ctrl_q | output | 8 | Control register readback |
| stat_clr | input | 1 | Clears the sticky status flags |
| status | output | 8 | {3'b0, abort, overrun, parity error, gap error, word ready} |
| word_data | output | WORD_W | Received word in natural bit order |
| word_valid | output | 1 | A received word is on offer |
| word_ready | input | 1 | Downstream accepts the word on offer |

## Verification
If the bit counter or shift register ends up in a wrong state, the next word offered shows it: the value is wrong, the word never arrives, or an extra word appears, all within one word time. A wrong NULL count shows at the start of the next word, either as a gap or abort flag where none is expected or as a short-gap word that is delivered anyway. A fault in the output holding stage shows in the same cycle as `word_valid`, because `word_data` changes while the word is waiting or the overrun flag is missing after a second word.

// File: rtl/a429rx_pkg.sv
package a429rx_pkg;
  typedef enum logic [1:0] {
    LV_NULL = 2'd0,
    LV_ONE  = 2'd1,
    LV_ZERO = 2'd2
  } line_lvl_e;

  localparam int CTRL_RATE = 0;
  localparam int CTRL_PAR  = 1;

  localparam int ST_RDY = 0;
  localparam int ST_GAP = 1;
  localparam int ST_PAR = 2;
  localparam int ST_OVR = 3;
  localparam int ST_ABT = 4;
endpackage

// File: rtl/a429rx_tick.sv
module a429rx_tick #(
  parameter int DIV_HI = 4,
  parameter int DIV_LO = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_hi,
  output logic tick
);
  localparam int DMAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
  localparam int CW   = $clog2(DMAX);
  localparam logic [CW-1:0] TOP_HI = CW'(DIV_HI - 1);
  localparam logic [CW-1:0] TOP_LO = CW'(DIV_LO - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] top;

  assign top = rate_hi ? TOP_HI : TOP_LO;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= top) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R7
endmodule

// File: rtl/a429rx_line.sv
module a429rx_line
  import a429rx_pkg::*;
#(
  parameter int SYNC    = 2,
  parameter int MIN_RUN = 3,
  parameter int GAP_MIN = 64
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             tick,
  input  logic                             a_in,
  input  logic                             b_in,
  output logic                             bit_stb,
  output logic                             bit_val,
  output logic [$clog2(GAP_MIN+1)-1:0]     null_len,
  output logic [$clog2(GAP_MIN+1)-1:0]     gap_len
);
  localparam int NW = $clog2(GAP_MIN + 1);
  localparam int RW = $clog2(MIN_RUN + 1);
  localparam logic [NW-1:0] NSAT = NW'(GAP_MIN);
  localparam logic [RW-1:0] RMAX = RW'(MIN_RUN);

  logic [SYNC-1:0] a_sy, b_sy;
  line_lvl_e       lvl_now, lvl_prev;
  logic [RW-1:0]   run, run_nx;
  logic            accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_sy <= '0;
      b_sy <= '0;
    end else begin
      a_sy <= {a_sy[SYNC-2:0], a_in};
      b_sy <= {b_sy[SYNC-2:0], b_in};
    end
  end

  always_comb begin
    case ({a_sy[SYNC-1], b_sy[SYNC-1]})
      2'b10:   lvl_now = LV_ONE;
      2'b01:   lvl_now = LV_ZERO;
      default: lvl_now = LV_NULL;
    endcase
  end

  always_comb begin
    if (lvl_now != lvl_prev)  run_nx = RW'(1);
    else if (run == RMAX)     run_nx = run;
    else                      run_nx = run + 1'b1;
  end

  assign accept = tick && (lvl_now != LV_NULL) && (run_nx == RMAX) &&
                  !((lvl_now == lvl_prev) && (run == RMAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_prev <= LV_NULL;
      run      <= '0;
      null_len <= '0;
      gap_len  <= '0;
      bit_stb  <= 1'b0;
      bit_val  <= 1'b0;
    end else begin
      bit_stb <= 1'b0;
      if (tick) begin
        lvl_prev <= lvl_now;
        run      <= run_nx;
        if (lvl_now == LV_NULL) begin
          if (null_len != NSAT) null_len <= null_len + 1'b1;
        end else begin
          null_len <= '0;
          if (lvl_prev == LV_NULL) gap_len <= null_len;
        end
        if (accept) begin
          bit_stb <= 1'b1;
          bit_val <= (lvl_now == LV_ONE);
        end
      end
    end
  end

  AST_ONE_BIT_PER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb); // R1
endmodule

// File: rtl/a429rx_frame.sv
module a429rx_frame #(
  parameter int WORD_W  = 32,
  parameter int LABEL_W = 8,
  parameter int GAP_MIN = 64,
  parameter int ABORT   = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bit_stb,
  input  logic                          bit_val,
  input  logic [$clog2(GAP_MIN+1)-1:0]  null_len,
  input  logic [$clog2(GAP_MIN+1)-1:0]  gap_len,
  output logic                          done,
  output logic [WORD_W-1:0]             data,
  output logic                          gap_bad,
  output logic                          par_ok,
  output logic                          abort
);
  localparam int NW = $clog2(GAP_MIN + 1);
  localparam int CW = $clog2(WORD_W);
  localparam logic [NW-1:0] GAP_LIM = NW'(GAP_MIN);
  localparam logic [NW-1:0] ABT_LIM = NW'(ABORT);
  localparam logic [CW-1:0] LAST    = CW'(WORD_W - 1);

  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] sh, sh_nx, word_asm;
  logic              gap_bad_q;

  assign sh_nx = {bit_val, sh[WORD_W-1:1]};

  for (genvar i = 0; i < LABEL_W; i++) begin : g_label_rev
    assign word_asm[LABEL_W-1-i] = sh_nx[i];
  end
  assign word_asm[WORD_W-1:LABEL_W] = sh_nx[WORD_W-1:LABEL_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      sh        <= '0;
      gap_bad_q <= 1'b0;
      done      <= 1'b0;
      data      <= '0;
      gap_bad   <= 1'b0;
      par_ok    <= 1'b0;
      abort     <= 1'b0;
    end else begin
      done  <= 1'b0;
      abort <= 1'b0;
      if ((cnt != '0) && (null_len > ABT_LIM)) begin
        cnt   <= '0;
        abort <= 1'b1;
      end else if (bit_stb) begin
        sh <= sh_nx;
        if (cnt == '0) gap_bad_q <= (gap_len < GAP_LIM);
        if (cnt == LAST) begin
          cnt     <= '0;
          done    <= 1'b1;
          data    <= word_asm;
          gap_bad <= gap_bad_q;
          par_ok  <= ^word_asm;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_DONE_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bit_stb)); // R2
endmodule

// File: rtl/a429_word_rx.sv
module a429_word_rx
  import a429rx_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int LABEL_W    = 8,
  parameter int OVS        = 16,
  parameter int MIN_RUN    = 3,
  parameter int GAP_BITS   = 4,
  parameter int ABORT_BITS = 2,
  parameter int DIV_HI     = 4,
  parameter int DIV_LO     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_a,
  input  logic              line_b,
  input  logic              ctrl_we,
  input  logic [7:0]        ctrl_wdata,
  output logic [7:0]        ctrl_q,
  input  logic              stat_clr,
  output logic [7:0]        status,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid,
  input  logic              word_ready
);
  localparam int GAP_MIN = GAP_BITS * OVS;
  localparam int ABORT   = ABORT_BITS * OVS;
  localparam int NW      = $clog2(GAP_MIN + 1);

  logic              rate_hi, par_en;
  logic              tick;
  logic              bit_stb, bit_val;
  logic [NW-1:0]     null_len, gap_len;
  logic              fr_done, fr_gap_bad, fr_par_ok, fr_abort;
  logic [WORD_W-1:0] fr_data;
  logic              word_ok, load;
  logic              gap_e, par_e, ovr_e, abt_e;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_hi <= 1'b1;
      par_en  <= 1'b1;
    end else if (ctrl_we) begin
      rate_hi <= ctrl_wdata[CTRL_RATE];
      par_en  <= ctrl_wdata[CTRL_PAR];
    end
  end
  assign ctrl_q = {6'b0, par_en, rate_hi};

  a429rx_tick #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO)) u_tick (
    .clk(clk), .rst_n(rst_n), .rate_hi(rate_hi), .tick(tick)
  );

  a429rx_line #(.SYNC(2), .MIN_RUN(MIN_RUN), .GAP_MIN(GAP_MIN)) u_line (
    .clk(clk), .rst_n(rst_n), .tick(tick), .a_in(line_a), .b_in(line_b),
    .bit_stb(bit_stb), .bit_val(bit_val), .null_len(null_len), .gap_len(gap_len)
  );

  a429rx_frame #(.WORD_W(WORD_W), .LABEL_W(LABEL_W), .GAP_MIN(GAP_MIN),
                 .ABORT(ABORT)) u_frame (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
    .null_len(null_len), .gap_len(gap_len), .done(fr_done), .data(fr_data),
    .gap_bad(fr_gap_bad), .par_ok(fr_par_ok), .abort(fr_abort)
  );

  assign word_ok = fr_done && !fr_gap_bad && (fr_par_ok || !par_en);
  assign load    = word_ok && (!word_valid || word_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_valid <= 1'b0;
      word_data  <= '0;
    end else if (load) begin
      word_valid <= 1'b1;
      word_data  <= fr_data;
    end else if (word_ready) begin
      word_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_e <= 1'b0;
      par_e <= 1'b0;
      ovr_e <= 1'b0;
      abt_e <= 1'b0;
    end else begin
      if (stat_clr) begin
        gap_e <= 1'b0;
        par_e <= 1'b0;
        ovr_e <= 1'b0;
        abt_e <= 1'b0;
      end
      if (fr_done && fr_gap_bad) gap_e <= 1'b1;
      if (fr_done && !fr_gap_bad && par_en && !fr_par_ok) par_e <= 1'b1;
      if (word_ok && !load) ovr_e <= 1'b1;
      if (fr_abort) abt_e <= 1'b1;
    end
  end

  always_comb begin
    status         = '0;
    status[ST_RDY] = word_valid;
    status[ST_GAP] = gap_e;
    status[ST_PAR] = par_e;
    status[ST_OVR] = ovr_e;
    status[ST_ABT] = abt_e;
  end

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !word_ready |=> word_valid && $stable(word_data)); // R8
  AST_ODD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_valid) && $past(par_en) |-> ^word_data); // R3
  AST_GAP_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fr_done && fr_gap_bad |=> !$rose(word_valid)); // R5
endmodule

// File: tb/sim_a429_word_rx.sv
module sim_a429_word_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_a = 1'b0, line_b = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [7:0]  ctrl_wdata = 8'h00;
  logic [7:0]  ctrl_q;
  logic        stat_clr = 1'b0;
  logic [7:0]  status;
  logic [31:0] word_data;
  logic        word_valid;
  logic        word_ready = 1'b1;

  int checks = 0;
  int fails = 0;
  int sp = 4;
  bit finished = 1'b0;
  logic [31:0] expq[$];

  always #5 clk = ~clk;

  a429_word_rx u0 (
    .clk(clk), .rst_n(rst_n), .line_a(line_a), .line_b(line_b),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
    .stat_clr(stat_clr), .status(status), .word_data(word_data),
    .word_valid(word_valid), .word_ready(word_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] odd(input logic [31:0] w);
    logic [31:0] r = w;
    r[31] = ~(^w[30:0]);
    return r;
  endfunction

  task automatic hold(input logic a, input logic b, input int n);
    line_a = a;
    line_b = b;
    repeat (n * sp) @(negedge clk);
  endtask

  task automatic put_bit(input logic v);
    hold(v, ~v, 8);
    hold(1'b0, 1'b0, 8);
  endtask

  task automatic send(input logic [31:0] w, input int gap, input bit expect_it);
    if (expect_it) expq.push_back(w);
    hold(1'b0, 1'b0, gap);
    for (int i = 7; i >= 0; i--) put_bit(w[i]);
    for (int i = 8; i < 32; i++) put_bit(w[i]);
  endtask

  task automatic ctrl_wr(input logic [7:0] v);
    @(negedge clk);
    ctrl_we = 1'b1;
    ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
    sp = v[0] ? 4 : 32;
  endtask

  task automatic clr();
    @(negedge clk);
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk);
    #1 word_ready = v;
  endtask

  // monitor: pops the scoreboard at every handshake
  always @(negedge clk) begin
    if (rst_n && word_valid && word_ready) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R2 unexpected word", word_data, 32'h0);
      end else begin
        logic [31:0] e;
        e = expq.pop_front();
        chk(word_data == e, "R2 word content", word_data, e);
      end
    end
  end

  initial begin
    #1900000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] b1;
    repeat (4) @(negedge clk);
    chk(status == 8'h00, "R9 reset status", {24'h0, status}, 32'h0);
    chk(ctrl_q == 8'h03, "R9 reset ctrl", {24'h0, ctrl_q}, 32'h3);
    chk(word_valid == 1'b0, "R9 reset valid", {31'h0, word_valid}, 32'h0);
    rst_n = 1'b1;
    ctrl_wr(8'hFF);
    chk(ctrl_q == 8'h03, "R9 reserved ctrl bits", {24'h0, ctrl_q}, 32'h3);

    // main patterns, label reversal
    hold(1'b0, 1'b0, 80);
    send(odd(32'h2468ACE1), 64, 1);
    send(odd(32'h00000000), 64, 1);
    send(odd(32'hFFFFFFFF), 64, 1);
    send(odd(32'h000000C5), 64, 1);
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R2 words delivered", expq.size(), 0);
    chk(status == 8'h00, "R1 no error flags", {24'h0, status}, 32'h0);

    // R3 parity failure with checking on
    send(odd(32'h13572468) ^ 32'h80000000, 64, 0);
    repeat (4) @(negedge clk);
    chk(status == 8'h04, "R3 parity flag", {24'h0, status}, 32'h4);
    clr();
    chk(status == 8'h00, "R9 stat_clr", {24'h0, status}, 32'h0);

    // R5 short gap
    send(odd(32'h0F0F0F0F), 24, 0);
    repeat (4) @(negedge clk);
    chk(status == 8'h02, "R5 gap flag", {24'h0, status}, 32'h2);
    clr();
    send(odd(32'h55AA33CC), 64, 1);
    repeat (4) @(negedge clk);
    chk(status == 8'h00, "R5 recovery", {24'h0, status}, 32'h0);

    // R1 short glitches give no bit
    hold(1'b0, 1'b0, 20);
    hold(1'b1, 1'b0, 2);
    hold(1'b0, 1'b0, 20);
    hold(1'b0, 1'b1, 2);
    send(odd(32'h7E000081), 72, 1);
    repeat (4) @(negedge clk);
    chk(expq.size() == 0 && status == 8'h00, "R1 glitch rejected",
        {24'h0, status}, 32'h0);

    // R6 stalled word
    hold(1'b0, 1'b0, 64);
    for (int i = 0; i < 10; i++) put_bit(1'b1);
    hold(1'b0, 1'b0, 40);
    send(odd(32'hC0FFEE11), 40, 1);
    repeat (4) @(negedge clk);
    chk(status == 8'h10, "R6 abort flag", {24'h0, status}, 32'h10);
    chk(expq.size() == 0, "R6 next word intact", expq.size(), 0);
    clr();

    // R4 parity check off
    ctrl_wr(8'h01);
    send(odd(32'h1234ABCD) ^ 32'h80000000, 64, 1);
    repeat (4) @(negedge clk);
    chk(status == 8'h00, "R4 no parity flag", {24'h0, status}, 32'h0);
    chk(expq.size() == 0, "R4 delivered", expq.size(), 0);

    // R8 back-pressure
    ctrl_wr(8'h03);
    set_ready(1'b0);
    b1 = odd(32'hA5A5F00D);
    send(b1, 64, 1);
    send(odd(32'h0BADCAFE), 64, 0);
    repeat (4) @(negedge clk);
    chk(word_valid == 1'b1 && word_data == b1, "R8 word held", word_data, b1);
    chk(status == 8'h09, "R8 overrun flag", {24'h0, status}, 32'h9);
    set_ready(1'b1);
    repeat (4) @(negedge clk);
    chk(word_valid == 1'b0, "R8 released", {31'h0, word_valid}, 32'h0);
    chk(expq.size() == 0, "R8 first word kept", expq.size(), 0);
    clr();

    // R7 low speed
    ctrl_wr(8'h02);
    hold(1'b0, 1'b0, 80);
    send(odd(32'h3C3C5A5A), 64, 1);
    repeat (4) @(negedge clk);
    chk(expq.size() == 0 && status == 8'h00, "R7 low-speed word",
        {24'h0, status}, 32'h0);
    sp = 4;
    send(odd(32'h11112222), 64, 0);
    repeat (40) @(negedge clk);
    chk(word_valid == 1'b0 && status == 8'h00, "R7 fast pulses at low rate",
        {24'h0, status}, 32'h0);

    chk(expq.size() == 0, "R2 queue drained", expq.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule